// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 SDRAM interface. It walks the memory through its power-up and initialization sequence. Once power-good is seen, it holds the memory reset low, releases it, and waits before enabling the clock. After the clock is enabled it waits again before the first mode-register load. It then loads the four mode registers in a fixed order, issues a long ZQ calibration, and waits for DLL lock and calibration to finish. At the end it raises an init-done flag, which the normal controller uses to take over the command bus.

Every delay is an input in clock cycles, so one netlist serves any speed grade. A single down-counter times every interval and is reloaded on each state change. All pin outputs come from registers.

Dropping power-good at any point sends the machine back to its idle, reset-held state. When power-good returns, the whole sequence starts over.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While `rst` is high, whatever `i_pwr_ok` is: `o_ddr_reset_n`=0, `o_cke`=0, `o_odt`=0, `o_init_done`=0, the command is NOP ({cs_n,ras_n,cas_n,we_n}=4'b0111), and `o_ba` and `o_addr` are 0.
- R2: The first cycle after power-good is seen high in idle starts the reset hold. `o_ddr_reset_n` stays low for exactly max(`i_t_rst_hold`,1) cycles of that hold, and `o_cke` stays low throughout.
- R3: `o_cke` rises exactly max(`i_t_cke_wait`,1) cycles after `o_ddr_reset_n` rises. NOP is driven whenever `o_cke` is low.
- R4: The first mode-register command (MRS, {cs_n,ras_n,cas_n,we_n}=4'b0000) appears exactly max(`i_t_xpr`,1) cycles after `o_cke` rises.
- R5: Exactly four MRS commands are issued, in this order and with these values:
  - `o_ba`=3'b010 with `o_addr`=`i_mr2`;
  - `o_ba`=3'b011 with `o_addr`=`i_mr3`;
  - `o_ba`=3'b001 with `o_addr`=`i_mr1`, bit 0 forced to 0 (DLL enabled);
  - `o_ba`=3'b000 with `o_addr`=`i_mr0`, bit 8 forced to 1 (DLL reset).
- R6: Successive MRS commands are exactly max(`i_t_mrd`,1)+1 cycles apart, so two MRS never fall in adjacent cycles.
- R7: A ZQ long-calibration command ({cs_n,ras_n,cas_n,we_n}=4'b0110, `o_addr`=1<<10, `o_ba`=0) appears exactly max(`i_t_mod`,1)+1 cycles after the last MRS.
- R8: `o_init_done` rises exactly max(`i_t_dllk`,`i_t_zqinit`,1)+1 cycles after the ZQ command. It then stays high while power-good stays high.
- R9: Every cycle that carries no MRS or ZQ command drives NOP with `o_addr`=0 and `o_ba`=0. `o_odt` is always 0. Once `o_cke` rises it stays high until power-good is lost, and `o_cke` is never high while `o_ddr_reset_n` is low.
- R10: If `i_pwr_ok` is low at a clock edge, then after that edge `o_ddr_reset_n`=0, `o_cke`=0, `o_init_done`=0 and NOP is driven. When power-good returns, the full sequence of R2 to R8 runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| i_pwr_ok | input | 1 | Supply stable; low forces the reset-held idle state |
| i_mr0 | input | ADDR_W | Value for mode register 0 (DLL-reset bit forced on) |
| i_mr1 | input | ADDR_W | Value for mode register 1 (DLL-disable bit forced off) |
| i_mr2 | input | ADDR_W | Value for mode register 2 |
| i_mr3 | input | ADDR_W | Value for mode register 3 |
| i_t_rst_hold | input | CNT_W | Reset hold time, cycles |
| i_t_cke_wait | input | CNT_W | Wait from reset release to clock enable, cycles |
| i_t_xpr | input | CNT_W | Wait from clock enable to first mode load, cycles |
| i_t_mrd | input | CNT_W | Gap between mode loads, cycles |
| i_t_mod | input | CNT_W | Gap after last mode load, cycles |
| i_t_dllk | input | CNT_W | DLL lock time, cycles |
| i_t_zqinit | input | CNT_W | Initial calibration time, cycles |
| o_ddr_reset_n | output | 1 | Memory reset, active low |
| o_cke | output | 1 | Clock enable |
| o_odt | output | 1 | On-die termination control, held low |
| o_cs_n | output | 1 | Chip select, active low |
| o_ras_n | output | 1 | Row strobe, active low |
| o_cas_n | output | 1 | Column strobe, active low |
| o_we_n | output | 1 | Write enable, active low |
| o_ba | output | 3 | Bank address / mode-register select |
| o_addr | output | ADDR_W | Address / mode-register value |
| o_init_done | output | 1 | Initialization complete |

## Verification
Each output register loads from the state being entered at the same edge. A result is therefore visible in the first cycle of its state, and every R2 to R8 interval is an exact cycle distance between two output events. The bench samples on the falling edge and numbers its samples from the first reset-hold cycle. From the programmed delays it computes the sample index at which each edge or command is due, and compares the recorded indices with those sums. A power-good drop is due one cycle after the edge that sees it, so the bench checks the outputs at the very next sample. It repeats this with the drop placed at every second cycle of the sequence.

// File: rtl/ddr3_pwrup_pkg.sv
package ddr3_pwrup_pkg;

  localparam int BA_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HOLD, ST_CKEW, ST_XPR,
    ST_MR2,  ST_GAP2, ST_MR3,  ST_GAP3,
    ST_MR1,  ST_GAP1, ST_MR0,  ST_GAP0,
    ST_ZQ,   ST_ZQW,  ST_DONE
  } pwr_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_MRS  = 4'b0000;
  localparam logic [3:0] CMD_ZQCL = 4'b0110;

endpackage

// File: rtl/pwrup_delay_ctr.sv
module pwrup_delay_ctr #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && zero) |=> zero); // R2

endmodule

// File: rtl/pwrup_seq_fsm.sv
module pwrup_seq_fsm
  import ddr3_pwrup_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_ok,
  input  logic [CNT_W-1:0] t_rst_hold,
  input  logic [CNT_W-1:0] t_cke_wait,
  input  logic [CNT_W-1:0] t_xpr,
  input  logic [CNT_W-1:0] t_mrd,
  input  logic [CNT_W-1:0] t_mod,
  input  logic [CNT_W-1:0] t_dllk,
  input  logic [CNT_W-1:0] t_zqinit,
  input  logic             cnt_zero,
  output pwr_state_e       state_nxt,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val
);

  pwr_state_e       state_q;
  logic [CNT_W-1:0] t_final;

  // A wait of N cycles loads N-1; zero still gives one cycle.
  function automatic logic [CNT_W-1:0] less1(input logic [CNT_W-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  function automatic logic is_wait(input pwr_state_e s);
    return s inside {ST_HOLD, ST_CKEW, ST_XPR, ST_GAP2, ST_GAP3,
                     ST_GAP1, ST_GAP0, ST_ZQW};
  endfunction

  assign t_final = (t_dllk > t_zqinit) ? t_dllk : t_zqinit;

  always_comb begin
    state_nxt = state_q;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    case (state_q)
      ST_IDLE: if (pwr_ok) begin
        state_nxt = ST_HOLD; cnt_load = 1'b1; cnt_val = less1(t_rst_hold);
      end
      ST_HOLD: if (cnt_zero) begin
        state_nxt = ST_CKEW; cnt_load = 1'b1; cnt_val = less1(t_cke_wait);
      end
      ST_CKEW: if (cnt_zero) begin
        state_nxt = ST_XPR; cnt_load = 1'b1; cnt_val = less1(t_xpr);
      end
      ST_XPR:  if (cnt_zero) state_nxt = ST_MR2;
      ST_MR2:  begin
        state_nxt = ST_GAP2; cnt_load = 1'b1; cnt_val = less1(t_mrd);
      end
      ST_GAP2: if (cnt_zero) state_nxt = ST_MR3;
      ST_MR3:  begin
        state_nxt = ST_GAP3; cnt_load = 1'b1; cnt_val = less1(t_mrd);
      end
      ST_GAP3: if (cnt_zero) state_nxt = ST_MR1;
      ST_MR1:  begin
        state_nxt = ST_GAP1; cnt_load = 1'b1; cnt_val = less1(t_mrd);
      end
      ST_GAP1: if (cnt_zero) state_nxt = ST_MR0;
      ST_MR0:  begin
        state_nxt = ST_GAP0; cnt_load = 1'b1; cnt_val = less1(t_mod);
      end
      ST_GAP0: if (cnt_zero) state_nxt = ST_ZQ;
      ST_ZQ:   begin
        state_nxt = ST_ZQW; cnt_load = 1'b1; cnt_val = less1(t_final);
      end
      ST_ZQW:  if (cnt_zero) state_nxt = ST_DONE;
      ST_DONE: state_nxt = ST_DONE;
      default: state_nxt = ST_IDLE;
    endcase
    if (!pwr_ok) begin
      state_nxt = ST_IDLE;
      cnt_load  = 1'b0;
      cnt_val   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_nxt;
  end

  AST_WAIT_EXPIRED: assert property (@(posedge clk) disable iff (rst)
    (is_wait(state_q) && pwr_ok && (state_nxt != state_q)) |-> cnt_zero); // R4

endmodule

// File: rtl/pwrup_cmd_out.sv
module pwrup_cmd_out
  import ddr3_pwrup_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  pwr_state_e        state_nxt,
  input  logic [ADDR_W-1:0] mr0,
  input  logic [ADDR_W-1:0] mr1,
  input  logic [ADDR_W-1:0] mr2,
  input  logic [ADDR_W-1:0] mr3,
  output logic              reset_n_q,
  output logic              cke_q,
  output logic              odt_q,
  output logic [3:0]        cmd_q,
  output logic [BA_W-1:0]   ba_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              done_q
);

  localparam int DLL_OFF_BIT = 0;
  localparam int DLL_RST_BIT = 8;
  localparam int ZQ_LONG_BIT = 10;

  logic              reset_n_d, cke_d, done_d;
  logic [3:0]        cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    reset_n_d = !(state_nxt inside {ST_IDLE, ST_HOLD});
    cke_d     = !(state_nxt inside {ST_IDLE, ST_HOLD, ST_CKEW});
    done_d    = (state_nxt == ST_DONE);
    cmd_d     = CMD_NOP;
    ba_d      = '0;
    addr_d    = '0;
    case (state_nxt)
      ST_MR2: begin cmd_d = CMD_MRS; ba_d = 3'b010; addr_d = mr2; end
      ST_MR3: begin cmd_d = CMD_MRS; ba_d = 3'b011; addr_d = mr3; end
      ST_MR1: begin
        cmd_d = CMD_MRS; ba_d = 3'b001; addr_d = mr1;
        addr_d[DLL_OFF_BIT] = 1'b0;
      end
      ST_MR0: begin
        cmd_d = CMD_MRS; ba_d = 3'b000; addr_d = mr0;
        addr_d[DLL_RST_BIT] = 1'b1;
      end
      ST_ZQ: begin
        cmd_d = CMD_ZQCL; addr_d[ZQ_LONG_BIT] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_n_q <= 1'b0;
      cke_q     <= 1'b0;
      odt_q     <= 1'b0;
      cmd_q     <= CMD_NOP;
      ba_q      <= '0;
      addr_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      reset_n_q <= reset_n_d;
      cke_q     <= cke_d;
      odt_q     <= 1'b0;
      cmd_q     <= cmd_d;
      ba_q      <= ba_d;
      addr_q    <= addr_d;
      done_q    <= done_d;
    end
  end

  AST_CKE_NEEDS_RESET_OFF: assert property (@(posedge clk) disable iff (rst)
    cke_q |-> reset_n_q); // R9

endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
  import ddr3_pwrup_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i_pwr_ok,
  input  logic [ADDR_W-1:0] i_mr0,
  input  logic [ADDR_W-1:0] i_mr1,
  input  logic [ADDR_W-1:0] i_mr2,
  input  logic [ADDR_W-1:0] i_mr3,
  input  logic [CNT_W-1:0]  i_t_rst_hold,
  input  logic [CNT_W-1:0]  i_t_cke_wait,
  input  logic [CNT_W-1:0]  i_t_xpr,
  input  logic [CNT_W-1:0]  i_t_mrd,
  input  logic [CNT_W-1:0]  i_t_mod,
  input  logic [CNT_W-1:0]  i_t_dllk,
  input  logic [CNT_W-1:0]  i_t_zqinit,
  output logic              o_ddr_reset_n,
  output logic              o_cke,
  output logic              o_odt,
  output logic              o_cs_n,
  output logic              o_ras_n,
  output logic              o_cas_n,
  output logic              o_we_n,
  output logic [2:0]        o_ba,
  output logic [ADDR_W-1:0] o_addr,
  output logic              o_init_done
);

  pwr_state_e       state_nxt;
  logic             cnt_load, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic [3:0]       cmd;

  pwrup_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .pwr_ok(i_pwr_ok),
    .t_rst_hold(i_t_rst_hold), .t_cke_wait(i_t_cke_wait), .t_xpr(i_t_xpr),
    .t_mrd(i_t_mrd), .t_mod(i_t_mod), .t_dllk(i_t_dllk), .t_zqinit(i_t_zqinit),
    .cnt_zero(cnt_zero), .state_nxt(state_nxt),
    .cnt_load(cnt_load), .cnt_val(cnt_val)
  );

  pwrup_delay_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  pwrup_cmd_out #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .state_nxt(state_nxt),
    .mr0(i_mr0), .mr1(i_mr1), .mr2(i_mr2), .mr3(i_mr3),
    .reset_n_q(o_ddr_reset_n), .cke_q(o_cke), .odt_q(o_odt),
    .cmd_q(cmd), .ba_q(o_ba), .addr_q(o_addr), .done_q(o_init_done)
  );

  assign {o_cs_n, o_ras_n, o_cas_n, o_we_n} = cmd;

  AST_PWR_LOSS: assert property (@(posedge clk) disable iff (rst)
    !i_pwr_ok |=> (!o_ddr_reset_n && !o_cke && !o_init_done && cmd == CMD_NOP)); // R10
  AST_CKE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (o_cke && i_pwr_ok) |=> o_cke); // R9
  AST_CKE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $rose(o_cke) |-> $past(o_ddr_reset_n)); // R3
  AST_NOP_WITHOUT_CKE: assert property (@(posedge clk) disable iff (rst)
    !o_cke |-> (cmd == CMD_NOP)); // R3
  AST_MRS_SPACED: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_MRS) |=> (cmd != CMD_MRS)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (o_init_done && i_pwr_ok) |=> o_init_done); // R8

endmodule

// File: tb/ddr3_pwrup_seq_bench.sv
module ddr3_pwrup_seq_bench;

  localparam int AW = 14;
  localparam int CW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b0;
  logic [AW-1:0] mr0 = 14'h0061, mr1 = 14'h0045, mr2 = 14'h0018, mr3 = 14'h0004;
  logic [CW-1:0] t_rst, t_cke, t_xpr, t_mrd, t_mod, t_dllk, t_zq;
  logic rn, cke, odt, cs_n, ras_n, cas_n, we_n, done;
  logic [2:0] ba;
  logic [AW-1:0] addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ddr3_pwrup_seq #(.ADDR_W(AW), .CNT_W(CW)) u_ddr3_pwrup_seq (
    .clk(clk), .rst(rst), .i_pwr_ok(pwr_ok),
    .i_mr0(mr0), .i_mr1(mr1), .i_mr2(mr2), .i_mr3(mr3),
    .i_t_rst_hold(t_rst), .i_t_cke_wait(t_cke), .i_t_xpr(t_xpr),
    .i_t_mrd(t_mrd), .i_t_mod(t_mod), .i_t_dllk(t_dllk), .i_t_zqinit(t_zq),
    .o_ddr_reset_n(rn), .o_cke(cke), .o_odt(odt),
    .o_cs_n(cs_n), .o_ras_n(ras_n), .o_cas_n(cas_n), .o_we_n(we_n),
    .o_ba(ba), .o_addr(addr), .o_init_done(done)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int atl1(int x);
    return (x < 1) ? 1 : x;
  endfunction

  task automatic set_cfg(int c);
    case (c)
      0: begin t_rst=3; t_cke=4; t_xpr=2; t_mrd=1; t_mod=2;  t_dllk=5;  t_zq=3;  end
      1: begin t_rst=0; t_cke=0; t_xpr=0; t_mrd=0; t_mod=0;  t_dllk=0;  t_zq=0;  end
      2: begin t_rst=1; t_cke=1; t_xpr=1; t_mrd=1; t_mod=1;  t_dllk=1;  t_zq=1;  end
      3: begin t_rst=7; t_cke=5; t_xpr=6; t_mrd=4; t_mod=12; t_dllk=9;  t_zq=11; end
      default: begin t_rst=2; t_cke=3; t_xpr=5; t_mrd=2; t_mod=3; t_dllk=20; t_zq=4; end
    endcase
  endtask

  // Sample index of init_done, counted from the first reset-hold cycle (1).
  function automatic int done_index();
    int nz;
    nz = atl1((int'(t_dllk) > int'(t_zq)) ? int'(t_dllk) : int'(t_zq));
    return 1 + atl1(int'(t_rst)) + atl1(int'(t_cke)) + atl1(int'(t_xpr))
           + 3 * (atl1(int'(t_mrd)) + 1) + atl1(int'(t_mod)) + 1 + nz + 1;
  endfunction

  task automatic begin_seq();
    @(negedge clk); pwr_ok = 1'b0;
    @(negedge clk); pwr_ok = 1'b1;
  endtask

  task automatic run_seq();
    int kr = -1, kc = -1, kzq = -1, kd = -1, nm = 0;
    int kmr[4], bas[4], adr[4];
    int zq_addr = -1, zq_ba = -1;
    bit nop_ok = 1, cke_ok = 1, odt_ok = 1, done_ok = 1;
    int nz;
    logic [3:0] cmd;
    for (int i = 0; i < 4; i++) begin kmr[i] = -1; bas[i] = -1; adr[i] = -1; end
    begin_seq();
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      cmd = {cs_n, ras_n, cas_n, we_n};
      if (rn && kr < 0) kr = k;
      if (cke && kc < 0) kc = k;
      if (kc > 0 && !cke) cke_ok = 0;
      if (cke && !rn) cke_ok = 0;
      if (odt) odt_ok = 0;
      if (cmd == 4'b0000) begin
        if (nm < 4) begin kmr[nm] = k; bas[nm] = int'(ba); adr[nm] = int'(addr); end
        nm++;
      end else if (cmd == 4'b0110 && kzq < 0) begin
        kzq = k; zq_addr = int'(addr); zq_ba = int'(ba);
      end else if (cmd != 4'b0111 || addr != '0 || ba != '0) begin
        nop_ok = 0;
      end
      if (done && kd < 0) kd = k;
      if (kd > 0 && !done) done_ok = 0;
      if (kd > 0 && k >= kd + 4) break;
    end
    nz = atl1((int'(t_dllk) > int'(t_zq)) ? int'(t_dllk) : int'(t_zq));
    check_eq("R2", "reset release index", kr, 1 + atl1(int'(t_rst)));
    check_eq("R3", "cke rise after reset release", kc - kr, atl1(int'(t_cke)));
    check_eq("R4", "first MRS after cke", kmr[0] - kc, atl1(int'(t_xpr)));
    check_eq("R5", "MRS count", nm, 4);
    check_eq("R5", "MR2 bank", bas[0], 2);
    check_eq("R5", "MR3 bank", bas[1], 3);
    check_eq("R5", "MR1 bank", bas[2], 1);
    check_eq("R5", "MR0 bank", bas[3], 0);
    check_eq("R5", "MR2 value", adr[0], int'(mr2));
    check_eq("R5", "MR3 value", adr[1], int'(mr3));
    check_eq("R5", "MR1 value", adr[2], int'(mr1) & ~1);
    check_eq("R5", "MR0 value", adr[3], int'(mr0) | (1 << 8));
    for (int i = 0; i < 3; i++)
      check_eq("R6", "MRS spacing", kmr[i+1] - kmr[i], atl1(int'(t_mrd)) + 1);
    check_eq("R7", "ZQ after last MRS", kzq - kmr[3], atl1(int'(t_mod)) + 1);
    check_eq("R7", "ZQ address", zq_addr, 1 << 10);
    check_eq("R7", "ZQ bank", zq_ba, 0);
    check_eq("R8", "done after ZQ", kd - kzq, nz + 1);
    check_eq("R8", "done index", kd, done_index());
    check_eq("R8", "done sticky", int'(done_ok), 1);
    check_eq("R9", "idle cycles are NOP", int'(nop_ok), 1);
    check_eq("R9", "cke held and gated by reset", int'(cke_ok), 1);
    check_eq("R9", "odt low", int'(odt_ok), 1);
  endtask

  task automatic drop_at(int d);
    begin_seq();
    repeat (d) @(negedge clk);
    pwr_ok = 1'b0;
    @(negedge clk);
    check_eq("R10", "state after power loss {rn,cke,done,cmd}",
             int'({rn, cke, done, cs_n, ras_n, cas_n, we_n}), 7);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(150000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    set_cfg(0);
    repeat (2) @(negedge clk);
    pwr_ok = 1'b1;
    @(negedge clk);
    check_eq("R1", "reset outputs {rn,cke,odt,done,cmd}",
             int'({rn, cke, odt, done, cs_n, ras_n, cas_n, we_n}), 7);
    check_eq("R1", "reset ba/addr", int'({ba, addr}), 0);
    pwr_ok = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 5; c++) begin
      set_cfg(c);
      run_seq();
      for (int d = 1; d <= done_index() + 2; d += 2) drop_at(d);
      run_seq(); // R10: full restart after loss
    end
    finish_run();
  end

endmodule